// File: doc/BRIEF.md
# Remappable Peripheral Pin Crossbar

This block sits between a bank of general-purpose pads and a set of digital peripherals and decides, under register control, which pad feeds each peripheral input and which peripheral output drives each pad. Input routing is chosen per peripheral input: one select register per input names the pad it listens to. Output routing is chosen per pad: one select register per pad names the peripheral output that drives it. Because the two register sets are separate, a peripheral's input and output can land on any two pads independently.

Pad ownership follows a fixed order. An analog-enabled pad belongs to the analog side, and the crossbar neither drives it nor forwards its level. Otherwise a pad whose output select is valid is driven by the chosen peripheral, overriding the plain GPIO latch and direction bit. Otherwise the pad falls back to GPIO. A routed input only sees pad data when that pad's tristate bit marks it as an input. Unprogrammed inputs read a per-input idle level. Pad levels pass through a two-flop synchronizer before the input crossbar.

A lock bit protects the select registers. It toggles only when a key write of `0xA5` to the key address is followed on the very next cycle by a key write of `0x5A`. While it is set, writes to the select registers are dropped.

Top module: `remap_xbar`

## Requirements
- R1: Reset (synchronous, active high) sets every input select to 15 (unmapped), every output select to 0 and clears the lock. During reset every peripheral input reads its idle level and every pad follows its GPIO latch and direction.
- R2: An input select value v below NUM_PINS routes pad v to that peripheral input, two clock edges after the pad changes (synchronizer). Any value of NUM_PINS or above gives the input's idle level (IN_IDLE bit).
- R3: A routed input shows pad data only while that pad's tristate bit is 1 (input). With the bit at 0 the input reads its idle level.
- R4: When a pad's analog-enable is 1, pad_oe and pad_out of that pad are 0 and any input routed to it reads its idle level.
- R5: An output select value k in 1..NUM_PIN_OUT drives the pad with periph_out[k-1] and enables it with periph_oe[k-1], whatever the pad's GPIO latch and tristate bits say.
- R6: An output select of 0 or above NUM_PIN_OUT leaves the pad on GPIO: pad_out is the latch bit and pad_oe is the inverse of the tristate bit.
- R7: While the lock is set, writes to input select addresses (0..NUM_PIN_IN-1) and output select addresses (NUM_PIN_IN..NUM_PIN_IN+NUM_PINS-1) change no register.
- R8: The lock lives at the key address (all ones); reading it returns the lock in bit 0. It toggles only when a write of 0xA5 to that address is followed on the next cycle by a write of 0x5A to it. A lone 0x5A or a pair with a gap changes nothing.
- R9: An accepted select write takes effect at the next clock edge; rd_data combinationally returns the addressed select value zero-extended (0 for unused addresses). Only the low 4 bits of write data are stored.
- R10: Several peripheral inputs may select the same pad, and each one sees that pad's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data for rd_addr |
| pad_in | input | NUM_PINS | Raw pad levels |
| pin_tris | input | NUM_PINS | GPIO direction per pad, 1 = input |
| pin_lat | input | NUM_PINS | GPIO output latch per pad |
| pin_analog | input | NUM_PINS | Analog-enable per pad |
| periph_out | input | NUM_PIN_OUT | Peripheral output levels |
| periph_oe | input | NUM_PIN_OUT | Peripheral output enables |
| periph_in | output | NUM_PIN_IN | Routed peripheral input levels |
| pad_out | output | NUM_PINS | Pad output level |
| pad_oe | output | NUM_PINS | Pad output enable |

## Verification
The hardest state to reach from the ports is a locked crossbar that receives select writes, because the lock moves only after an exact two-write key sequence on adjacent cycles. The stimulus first sends a lone second key and a key pair split by an idle cycle, which must leave the lock open, then the proper pair, then write new select values while steering rd_addr at the written addresses so dropped writes show up on rd_data. Random phases mix pad levels, direction, analog enables and peripheral drives against a behavioural model compared every cycle, with several inputs sharing one pad.

// File: rtl/remap_pkg.sv
package remap_pkg;

    localparam int SEL_W  = 4;
    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] KEY_ARM  = 8'hA5;
    localparam logic [DATA_W-1:0] KEY_FIRE = 8'h5A;

    typedef enum logic [1:0] {
        OWN_GPIO   = 2'd0,
        OWN_REMAP  = 2'd1,
        OWN_ANALOG = 2'd2
    } pin_owner_e;

    typedef struct packed {
        logic drv;
        logic en;
    } pad_drive_t;

    typedef struct packed {
        logic hit;
        logic data;
        logic is_in;
        logic analog;
    } in_tap_t;

    function automatic pin_owner_e pick_owner(input logic analog, input logic remapped);
        if (analog)
            return OWN_ANALOG;
        else if (remapped)
            return OWN_REMAP;
        else
            return OWN_GPIO;
    endfunction

endpackage

// File: rtl/remap_sync.sv
module remap_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_in;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;
endmodule

// File: rtl/remap_cfg.sv
module remap_cfg
    import remap_pkg::*;
#(
    parameter int NUM_PIN_IN = 4,
    parameter int NUM_PINS   = 8,
    parameter int ADDR_W     = 5
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_en,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic [DATA_W-1:0]                    wr_data,
    input  logic [ADDR_W-1:0]                    rd_addr,
    output logic [DATA_W-1:0]                    rd_data,
    output logic [NUM_PIN_IN-1:0][SEL_W-1:0]     in_sel,
    output logic [NUM_PINS-1:0][SEL_W-1:0]       out_sel,
    output logic                                 locked
);
    localparam int               OUT_BASE = NUM_PIN_IN;
    localparam logic [ADDR_W-1:0] KEY_ADDR = '1;

    logic arm_q;
    logic lock_q;
    logic key_wr;
    logic sel_wr;

    assign key_wr = wr_en && (wr_addr == KEY_ADDR);
    assign sel_wr = wr_en && !key_wr && !lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PIN_IN; i++) in_sel[i] <= '1;
            for (int p = 0; p < NUM_PINS; p++)   out_sel[p] <= '0;
        end else if (sel_wr) begin
            for (int i = 0; i < NUM_PIN_IN; i++)
                if (wr_addr == ADDR_W'(i)) in_sel[i] <= wr_data[SEL_W-1:0];
            for (int p = 0; p < NUM_PINS; p++)
                if (wr_addr == ADDR_W'(OUT_BASE + p)) out_sel[p] <= wr_data[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q  <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            arm_q <= key_wr && (wr_data == KEY_ARM);
            if (key_wr && (wr_data == KEY_FIRE) && arm_q)
                lock_q <= !lock_q;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_PIN_IN; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = DATA_W'(in_sel[i]);
        for (int p = 0; p < NUM_PINS; p++)
            if (rd_addr == ADDR_W'(OUT_BASE + p)) rd_data = DATA_W'(out_sel[p]);
        if (rd_addr == KEY_ADDR) rd_data = DATA_W'(lock_q);
    end

    assign locked = lock_q;
endmodule

// File: rtl/remap_in_route.sv
module remap_in_route
    import remap_pkg::*;
#(
    parameter int                    NUM_PIN_IN = 4,
    parameter int                    NUM_PINS   = 8,
    parameter logic [NUM_PIN_IN-1:0] IN_IDLE    = '0
) (
    input  logic [NUM_PIN_IN-1:0][SEL_W-1:0] in_sel,
    input  logic [NUM_PINS-1:0]              pin_sync,
    input  logic [NUM_PINS-1:0]              pin_tris,
    input  logic [NUM_PINS-1:0]              pin_analog,
    output logic [NUM_PIN_IN-1:0]            periph_in
);
    for (genvar i = 0; i < NUM_PIN_IN; i++) begin : g_in
        in_tap_t tap;
        logic    pass;

        always_comb begin
            tap = '0;
            for (int p = 0; p < NUM_PINS; p++) begin
                if (in_sel[i] == SEL_W'(p)) begin
                    tap.hit    = 1'b1;
                    tap.data   = pin_sync[p];
                    tap.is_in  = pin_tris[p];
                    tap.analog = pin_analog[p];
                end
            end
        end

        assign pass         = tap.hit && tap.is_in && !tap.analog;
        assign periph_in[i] = pass ? tap.data : IN_IDLE[i];
    end
endmodule

// File: rtl/remap_out_route.sv
module remap_out_route
    import remap_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int NUM_PIN_OUT = 6
) (
    input  logic [NUM_PINS-1:0][SEL_W-1:0] out_sel,
    input  logic [NUM_PIN_OUT-1:0]         periph_out,
    input  logic [NUM_PIN_OUT-1:0]         periph_oe,
    input  logic [NUM_PINS-1:0]            pin_lat,
    input  logic [NUM_PINS-1:0]            pin_tris,
    input  logic [NUM_PINS-1:0]            pin_analog,
    output logic [NUM_PINS-1:0]            pad_out,
    output logic [NUM_PINS-1:0]            pad_oe
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic       remapped;
        pad_drive_t src;
        pad_drive_t res;

        always_comb begin
            remapped = 1'b0;
            src      = '0;
            for (int k = 0; k < NUM_PIN_OUT; k++) begin
                if (out_sel[p] == SEL_W'(k + 1)) begin
                    remapped = 1'b1;
                    src.drv  = periph_out[k];
                    src.en   = periph_oe[k];
                end
            end
        end

        always_comb begin
            case (pick_owner(pin_analog[p], remapped))
                OWN_ANALOG: res = '0;
                OWN_REMAP:  res = src;
                default: begin
                    res.drv = pin_lat[p];
                    res.en  = !pin_tris[p];
                end
            endcase
        end

        assign pad_out[p] = res.drv;
        assign pad_oe[p]  = res.en;
    end
endmodule

// File: rtl/remap_xbar.sv
module remap_xbar
    import remap_pkg::*;
#(
    parameter int                    NUM_PINS    = 8,
    parameter int                    NUM_PIN_IN  = 4,
    parameter int                    NUM_PIN_OUT = 6,
    parameter int                    ADDR_W      = 5,
    parameter logic [NUM_PIN_IN-1:0] IN_IDLE     = 4'b1001
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [DATA_W-1:0]      rd_data,
    input  logic [NUM_PINS-1:0]    pad_in,
    input  logic [NUM_PINS-1:0]    pin_tris,
    input  logic [NUM_PINS-1:0]    pin_lat,
    input  logic [NUM_PINS-1:0]    pin_analog,
    input  logic [NUM_PIN_OUT-1:0] periph_out,
    input  logic [NUM_PIN_OUT-1:0] periph_oe,
    output logic [NUM_PIN_IN-1:0]  periph_in,
    output logic [NUM_PINS-1:0]    pad_out,
    output logic [NUM_PINS-1:0]    pad_oe
);
    logic [NUM_PIN_IN-1:0][SEL_W-1:0] in_sel;
    logic [NUM_PINS-1:0][SEL_W-1:0]   out_sel;
    logic                             locked;
    logic [NUM_PINS-1:0]              pin_sync;

    remap_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_in   (pad_in),
        .d_sync (pin_sync)
    );

    remap_cfg #(
        .NUM_PIN_IN (NUM_PIN_IN),
        .NUM_PINS   (NUM_PINS),
        .ADDR_W     (ADDR_W)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .in_sel  (in_sel),
        .out_sel (out_sel),
        .locked  (locked)
    );

    remap_in_route #(
        .NUM_PIN_IN (NUM_PIN_IN),
        .NUM_PINS   (NUM_PINS),
        .IN_IDLE    (IN_IDLE)
    ) u_in (
        .in_sel     (in_sel),
        .pin_sync   (pin_sync),
        .pin_tris   (pin_tris),
        .pin_analog (pin_analog),
        .periph_in  (periph_in)
    );

    remap_out_route #(
        .NUM_PINS    (NUM_PINS),
        .NUM_PIN_OUT (NUM_PIN_OUT)
    ) u_out (
        .out_sel    (out_sel),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .pin_lat    (pin_lat),
        .pin_tris   (pin_tris),
        .pin_analog (pin_analog),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );
endmodule

// File: rtl/remap_xbar_chk.sv
module remap_xbar_chk
    import remap_pkg::*;
#(
    parameter int                    NUM_PINS    = 8,
    parameter int                    NUM_PIN_IN  = 4,
    parameter int                    NUM_PIN_OUT = 6,
    parameter int                    ADDR_W      = 5,
    parameter logic [NUM_PIN_IN-1:0] IN_IDLE     = 4'b1001
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             wr_en,
    input logic [ADDR_W-1:0]                wr_addr,
    input logic [DATA_W-1:0]                wr_data,
    input logic [NUM_PIN_IN-1:0][SEL_W-1:0] in_sel,
    input logic [NUM_PINS-1:0][SEL_W-1:0]   out_sel,
    input logic                             locked,
    input logic [NUM_PINS-1:0]              pin_tris,
    input logic [NUM_PINS-1:0]              pin_analog,
    input logic [NUM_PIN_OUT-1:0]           periph_out,
    input logic [NUM_PIN_OUT-1:0]           periph_oe,
    input logic [NUM_PIN_IN-1:0]            periph_in,
    input logic [NUM_PINS-1:0]              pad_out,
    input logic [NUM_PINS-1:0]              pad_oe
);
    localparam logic [ADDR_W-1:0] KEY_ADDR = '1;

    assert_locked_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (locked && wr_en && (wr_addr != KEY_ADDR)) |=> ($stable(in_sel) && $stable(out_sel)));

    assert_lock_key_only_R8: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wr_addr == KEY_ADDR) && (wr_data == KEY_FIRE)) |=> $stable(locked));

    for (genvar i = 0; i < NUM_PIN_IN; i++) begin : g_ci
        assert_unmapped_idle_R2: assert property (@(posedge clk) disable iff (rst)
            (in_sel[i] >= SEL_W'(NUM_PINS)) |-> (periph_in[i] == IN_IDLE[i]));

        for (genvar p = 0; p < NUM_PINS; p++) begin : g_cp
            assert_dir_blocks_R3: assert property (@(posedge clk) disable iff (rst)
                ((in_sel[i] == SEL_W'(p)) && (!pin_tris[p] || pin_analog[p]))
                    |-> (periph_in[i] == IN_IDLE[i]));
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_cpin
        assert_analog_quiet_R4: assert property (@(posedge clk) disable iff (rst)
            pin_analog[p] |-> (!pad_oe[p] && !pad_out[p]));

        assert_gpio_fallback_R6: assert property (@(posedge clk) disable iff (rst)
            (!pin_analog[p] && (out_sel[p] == '0)) |-> (pad_oe[p] == !pin_tris[p]));

        for (genvar k = 0; k < NUM_PIN_OUT; k++) begin : g_ck
            assert_remap_drive_R5: assert property (@(posedge clk) disable iff (rst)
                (!pin_analog[p] && (out_sel[p] == SEL_W'(k + 1)))
                    |-> ((pad_oe[p] == periph_oe[k]) && (pad_out[p] == periph_out[k])));
        end
    end
endmodule

bind remap_xbar remap_xbar_chk #(
    .NUM_PINS    (NUM_PINS),
    .NUM_PIN_IN  (NUM_PIN_IN),
    .NUM_PIN_OUT (NUM_PIN_OUT),
    .ADDR_W      (ADDR_W),
    .IN_IDLE     (IN_IDLE)
) u_chk (.*);

// File: tb/sim_remap_xbar.sv
module sim_remap_xbar;
    localparam int       NP   = 8;
    localparam int       NI   = 4;
    localparam int       NO   = 6;
    localparam int       AW   = 5;
    localparam bit [3:0] IDLE = 4'b1001;
    localparam int       KEYA = 31;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic [NP-1:0] pad_in = '0, pin_tris = '1, pin_lat = '0, pin_analog = '0;
    logic [NO-1:0] periph_out = '0, periph_oe = '0;
    logic [NI-1:0] periph_in;
    logic [NP-1:0] pad_out, pad_oe;

    always #5 clk = ~clk;

    remap_xbar u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pad_in(pad_in), .pin_tris(pin_tris),
        .pin_lat(pin_lat), .pin_analog(pin_analog), .periph_out(periph_out),
        .periph_oe(periph_oe), .periph_in(periph_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;

    // behavioural reference state
    int       m_in [NI];
    int       m_out[NP];
    bit       m_lock, m_arm;
    bit [NP-1:0] s1, s2;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NI; i++) m_in[i] = 15;
            for (int p = 0; p < NP; p++) m_out[p] = 0;
            m_lock = 0; m_arm = 0; s1 = '0; s2 = '0;
        end else begin
            bit nxt_arm;
            s2 = s1;
            s1 = pad_in;
            nxt_arm = 0;
            if (wr_en) begin
                if (int'(wr_addr) == KEYA) begin
                    if (wr_data == 8'hA5) nxt_arm = 1;
                    if (wr_data == 8'h5A && m_arm) m_lock = !m_lock;
                end else if (!m_lock) begin
                    if (int'(wr_addr) < NI) m_in[wr_addr] = int'(wr_data[3:0]);
                    else if (int'(wr_addr) < NI + NP) m_out[int'(wr_addr) - NI] = int'(wr_data[3:0]);
                end
            end
            m_arm = nxt_arm;
        end
        started = 1;
    end

    task automatic check(input bit ok, input string tag, input string what, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // compare every cycle, between negedge stimulus and next posedge
    always @(negedge clk) begin
        #2;
        if (started && !done) begin
            for (int i = 0; i < NI; i++) begin
                int v; bit e; string tag; bit shared;
                v = m_in[i];
                shared = 0;
                for (int j = 0; j < NI; j++) if (j != i && m_in[j] == v) shared = 1;
                if (v < NP && pin_tris[v] && !pin_analog[v]) e = s2[v]; else e = IDLE[i];
                if (rst) tag = "R1";
                else if (v >= NP) tag = "R2";
                else if (pin_analog[v]) tag = "R4";
                else if (!pin_tris[v]) tag = "R3";
                else if (shared) tag = "R10";
                else tag = "R2";
                check(periph_in[i] == e, tag, $sformatf("periph_in[%0d]", i), int'(periph_in[i]), int'(e));
            end
            for (int p = 0; p < NP; p++) begin
                bit eo, ee; string tag; int k;
                k = m_out[p];
                if (pin_analog[p]) begin eo = 0; ee = 0; tag = "R4"; end
                else if (k >= 1 && k <= NO) begin eo = periph_out[k-1]; ee = periph_oe[k-1]; tag = "R5"; end
                else begin eo = pin_lat[p]; ee = !pin_tris[p]; tag = "R6"; end
                if (rst) tag = "R1";
                check(pad_out[p] == eo, tag, $sformatf("pad_out[%0d]", p), int'(pad_out[p]), int'(eo));
                check(pad_oe[p] == ee, tag, $sformatf("pad_oe[%0d]", p), int'(pad_oe[p]), int'(ee));
            end
            begin
                int a, er; string tag;
                a = int'(rd_addr);
                if (a < NI) er = m_in[a];
                else if (a < NI + NP) er = m_out[a - NI];
                else if (a == KEYA) er = int'(m_lock);
                else er = 0;
                if (rst) tag = "R1";
                else if (a == KEYA) tag = "R8";
                else if (m_lock) tag = "R7";
                else tag = "R9";
                check(int'(rd_data) == er, tag, $sformatf("rd_data@%0d", a), int'(rd_data), er);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1; wr_addr = AW'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rand_cycles(input int n, input bit allow_wr);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            pad_in     = NP'($urandom);
            pin_tris   = NP'($urandom | $urandom);
            pin_lat    = NP'($urandom);
            pin_analog = NP'($urandom & $urandom & $urandom);
            periph_out = NO'($urandom);
            periph_oe  = NO'($urandom);
            rd_addr    = AW'($urandom % 32);
            wr_en      = 0;
            if (allow_wr && ($urandom % 6 == 0)) begin
                wr_en   = 1;
                wr_addr = AW'($urandom % (NI + NP + 2));
                wr_data = 8'($urandom);
            end
        end
        @(negedge clk);
        wr_en = 0;
    endtask

    initial begin
        // R1: reset state observed during and after reset
        for (int a = 0; a < NI + NP; a++) begin
            @(negedge clk); rd_addr = AW'(a);
        end
        @(negedge clk); rd_addr = AW'(KEYA);
        rst = 0;
        for (int a = 0; a < NI + NP; a++) begin
            @(negedge clk); rd_addr = AW'(a);
        end

        // R2/R10 input routing, incl. shared pad and out-of-range value
        wr(0, 2); wr(1, 2); wr(2, 9); wr(3, 7);
        // R5/R6 output routing, incl. zero and out-of-range values; R9 upper bits dropped
        wr(NI + 0, 8'hF1); wr(NI + 3, 6); wr(NI + 5, 7); wr(NI + 6, 3);
        for (int a = 0; a < NI + NP; a++) begin
            @(negedge clk); rd_addr = AW'(a);
        end
        // R2 synchronizer latency: step pad 2 and 7
        @(negedge clk); pin_tris = '1; pin_analog = '0; pad_in = 8'h84;
        idle(4);
        @(negedge clk); pad_in = 8'h00;
        idle(4);
        rand_cycles(400, 1'b0);

        // rebuild a known map
        wr(0, 2); wr(1, 2); wr(2, 5); wr(3, 0);
        wr(NI + 1, 2); wr(NI + 4, 4); wr(NI + 7, 0);

        // R8: lone second key, split pair -> no toggle
        @(negedge clk); rd_addr = AW'(KEYA);
        wr(KEYA, 8'h5A); idle(2);
        wr(KEYA, 8'hA5); idle(1); wr(KEYA, 8'h5A); idle(2);
        // proper pair -> locked
        @(negedge clk); wr_en = 1; wr_addr = AW'(KEYA); wr_data = 8'hA5;
        @(negedge clk); wr_data = 8'h5A;
        @(negedge clk); wr_en = 0;
        idle(2);
        // R7: writes while locked must be dropped
        wr(0, 6); @(negedge clk); rd_addr = AW'(0); idle(1);
        wr(NI + 1, 5); @(negedge clk); rd_addr = AW'(NI + 1); idle(1);
        wr(2, 1); @(negedge clk); rd_addr = AW'(2); idle(1);
        rand_cycles(200, 1'b1);

        // unlock via the pair and keep going
        @(negedge clk); wr_en = 1; wr_addr = AW'(KEYA); wr_data = 8'hA5;
        @(negedge clk); wr_data = 8'h5A;
        @(negedge clk); wr_en = 0; rd_addr = AW'(KEYA);
        idle(2);
        wr(3, 4); @(negedge clk); rd_addr = AW'(3); idle(1);
        rand_cycles(600, 1'b1);

        idle(2);
        finish_run();
    end
endmodule